// File: doc/BRIEF.md
# Gated prescaled interval timer

This block is a 16-bit interval timer that counts ticks from one of three origins: every cycle of the peripheral clock, peripheral clock cycles while an external gate input is high, or rising edges of an external clock input. The external edge can be taken through a two-flop synchronizer or through a single sampling flop, which gives one cycle less latency. A prescaler divides the chosen tick stream by 1, 8, 64 or 256. The counter is compared with a period register. On the tick that finds the two equal, the counter goes back to zero and a sticky event flag is raised. In gated mode the falling edge of the gate also raises the flag, so software can measure the length of a pulse.

Software reaches four registers through a small write bus. The bus address has two parts: the upper two bits pick the register and the lower two bits pick the operation. The operation is a plain write, or a clear, set or invert alias that changes only the bits written as 1. A five-state machine (ST_OFF, ST_INTERNAL, ST_GATED, ST_EXT_SYNC, ST_EXT_RAW) is loaded from the control register. On every clock, any state moves to ST_OFF when the enable bit is clear. Otherwise it moves to the state decoded from the source-select, gate and sync bits. A new mode therefore takes effect one cycle after the control write.

Top module: `tmr_gated_interval`

## Requirements
- R1: In internal mode (control bit 15 = 1, bit 1 = 0, bit 7 = 0) the counter advances by one on each prescaled tick. On the tick after it equals period value P it returns to 0, so one full wrap takes (P+1) x divisor clock cycles.
- R2: The tick that returns the counter from the period value to 0 sets the event flag (register 3 bit 0, and the evt_flag output).
- R3: Control bits [5:4] select the prescale divisor: 00 gives 1, 01 gives 8, 10 gives 64 and 11 gives 256.
- R4: In gated mode (bit 7 = 1, bit 1 = 0) the gate input passes through two flops, and a peripheral clock cycle produces a tick only while the synchronized gate is high. A gate pulse N cycles long at divisor 1 advances the counter by exactly N, and the falling gate edge sets the event flag.
- R5: With bit 1 = 1 the counter counts rising edges of ext_clk, and the gate bit has no effect. Bit 2 = 1 samples ext_clk through two flops; bit 2 = 0 samples it through one flop.
- R6: While control bit 15 is 0 the counter holds its value.
- R7: bus_addr[3:2] selects the register: 0 control, 1 counter, 2 period, 3 flag. bus_addr[1:0] selects the operation: 0 write, 1 clear, 2 set, 3 invert. Alias operations change only the bits that are 1 in bus_wdata. bus_rdata returns the register selected by bus_addr[3:2]. Control bits other than 15, 7, 5, 4, 2 and 1 read as 0.
- R8: A write to the counter loads it and restarts the prescaler. A control write that changes bits [5:4] also restarts the prescaler. After a counter load at divisor 8, the first increment comes exactly 8 cycles later.
- R9: The event flag stays set until a clear-alias write to register 3 with bit 0 = 1. Plain, set and invert writes to register 3 leave it unchanged. A new event in the same cycle as a clear wins over the clear.
- R10: After reset the control register is 0x0000, the counter is 0x0000, the period register is 0xFFFF and the flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register select [3:2] and operation [1:0] |
| bus_wdata | input | 16 | Write data or alias bit mask |
| bus_rdata | output | 16 | Contents of the selected register |
| ext_clk | input | 1 | External count clock |
| gate_in | input | 1 | External gate for gated counting |
| evt_flag | output | 1 | Sticky timer event flag |

## Verification
The bench measures the wrap interval at all four prescale settings. A wrong divisor, or a wrap at P+2 or P, shows up there as an interval that is off by a whole multiple. A counter load in the middle of a prescale period is timed cycle by cycle: if the prescaler were not restarted, the first increment after the load would arrive early. Gate pulses of known length and bursts of external edges in both sampling depths show whether ticks leak while the gate is low, are lost to the synchronizer, or are blocked by a gate bit that should be ignored. Plain, set and invert writes to the flag register show whether anything other than the clear alias can drop the sticky flag.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    localparam int REG_W  = 16;
    localparam int ADDR_W = 4;

    // Control field positions (software visible layout)
    localparam int BIT_ON    = 15;
    localparam int BIT_GATE  = 7;
    localparam int BIT_PS_HI = 5;
    localparam int BIT_PS_LO = 4;
    localparam int BIT_SYNC  = 2;
    localparam int BIT_SEL   = 1;
    localparam logic [REG_W-1:0] CTRL_MASK = 16'h80B6;
    localparam logic [REG_W-1:0] PERIOD_RST = 16'hFFFF;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_COUNT  = 2'd1,
        REG_PERIOD = 2'd2,
        REG_FLAG   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_CLEAR  = 2'd1,
        OP_SET    = 2'd2,
        OP_INVERT = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_INTERNAL = 3'd1,
        ST_GATED    = 3'd2,
        ST_EXT_SYNC = 3'd3,
        ST_EXT_RAW  = 3'd4
    } src_state_e;

    function automatic logic [REG_W-1:0] apply_alias(
        input logic [REG_W-1:0] old_v,
        input logic [REG_W-1:0] data,
        input bus_op_e          op
    );
        logic [REG_W-1:0] res;
        unique case (op)
            OP_WRITE:  res = data;
            OP_CLEAR:  res = old_v & ~data;
            OP_SET:    res = old_v | data;
            OP_INVERT: res = old_v ^ data;
            default:   res = old_v;
        endcase
        return res;
    endfunction

    // Terminal value of the prescale counter for each divisor code
    function automatic int ps_limit(input logic [1:0] code);
        int lim;
        unique case (code)
            2'd0:    lim = 0;
            2'd1:    lim = 7;
            2'd2:    lim = 63;
            2'd3:    lim = 255;
            default: lim = 0;
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
    import tmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    input  logic [REG_W-1:0]     cnt_cur,
    input  logic                 set_evt,
    output logic                 en_bit,
    output logic                 gate_bit,
    output logic                 src_ext_bit,
    output logic                 sync_bit,
    output logic [1:0]           ps_code,
    output logic [REG_W-1:0]     period,
    output logic                 flag,
    output logic                 cnt_load,
    output logic [REG_W-1:0]     cnt_load_val,
    output logic                 pre_restart,
    output logic [REG_W-1:0]     bus_rdata
);

    reg_sel_e         sel;
    bus_op_e          op;
    logic [REG_W-1:0] ctrl;
    logic [REG_W-1:0] ctrl_new;
    logic             ctrl_we;
    logic             per_we;
    logic             flag_clr;

    assign sel      = reg_sel_e'(bus_addr[3:2]);
    assign op       = bus_op_e'(bus_addr[1:0]);
    assign ctrl_we  = bus_we && (sel == REG_CTRL);
    assign per_we   = bus_we && (sel == REG_PERIOD);
    assign cnt_load = bus_we && (sel == REG_COUNT);
    assign flag_clr = bus_we && (sel == REG_FLAG) && (op == OP_CLEAR) && bus_wdata[0];

    assign ctrl_new     = apply_alias(ctrl, bus_wdata, op) & CTRL_MASK;
    assign cnt_load_val = apply_alias(cnt_cur, bus_wdata, op);

    // Prescaler starts a fresh period on a counter load or a divisor change
    assign pre_restart = cnt_load ||
                         (ctrl_we && (ctrl_new[BIT_PS_HI:BIT_PS_LO] != ctrl[BIT_PS_HI:BIT_PS_LO]));

    assign en_bit      = ctrl[BIT_ON];
    assign gate_bit    = ctrl[BIT_GATE];
    assign src_ext_bit = ctrl[BIT_SEL];
    assign sync_bit    = ctrl[BIT_SYNC];
    assign ps_code     = ctrl[BIT_PS_HI:BIT_PS_LO];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl   <= '0;
            period <= PERIOD_RST;
            flag   <= 1'b0;
        end else begin
            if (ctrl_we) ctrl <= ctrl_new;
            if (per_we) period <= apply_alias(period, bus_wdata, op);
            if (set_evt) flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            REG_CTRL:   bus_rdata = ctrl;
            REG_COUNT:  bus_rdata = cnt_cur;
            REG_PERIOD: bus_rdata = period;
            REG_FLAG:   bus_rdata = {{(REG_W-1){1'b0}}, flag};
            default:    bus_rdata = '0;
        endcase
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag) else $error("flag dropped"); // R9

    AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == REG_PERIOD && op == OP_SET) |=>
        (period == ($past(period) | $past(bus_wdata)))) else $error("set alias"); // R7

endmodule

// File: rtl/tmr_srcsel.sv
`timescale 1ns/1ps
module tmr_srcsel
    import tmr_pkg::*;
#(
    parameter int SYNC_DEPTH = 3
)(
    input  logic clk,
    input  logic rst_n,
    input  logic en_bit,
    input  logic gate_bit,
    input  logic src_ext_bit,
    input  logic sync_bit,
    input  logic ext_clk,
    input  logic gate_in,
    output logic raw_tick,
    output logic gate_fall
);

    src_state_e            state;
    src_state_e            state_nx;
    src_state_e            target;
    logic [SYNC_DEPTH-1:0] ext_q;
    logic [SYNC_DEPTH-1:0] gate_q;

    // Input sampling chains: [0] first flop, [1] synchronized, [2] edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q  <= '0;
            gate_q <= '0;
        end else begin
            ext_q  <= {ext_q[SYNC_DEPTH-2:0], ext_clk};
            gate_q <= {gate_q[SYNC_DEPTH-2:0], gate_in};
        end
    end

    // Mode requested by the control bits
    always_comb begin
        if (!en_bit)          target = ST_OFF;
        else if (src_ext_bit) target = sync_bit ? ST_EXT_SYNC : ST_EXT_RAW;
        else if (gate_bit)    target = ST_GATED;
        else                  target = ST_INTERNAL;
    end

    // Next state: disable wins from any state, otherwise follow the request
    always_comb begin
        unique case (state)
            ST_OFF:      state_nx = target;
            ST_INTERNAL: state_nx = en_bit ? target : ST_OFF;
            ST_GATED:    state_nx = en_bit ? target : ST_OFF;
            ST_EXT_SYNC: state_nx = en_bit ? target : ST_OFF;
            ST_EXT_RAW:  state_nx = en_bit ? target : ST_OFF;
            default:     state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // Outputs per state
    always_comb begin
        raw_tick  = 1'b0;
        gate_fall = 1'b0;
        unique case (state)
            ST_OFF: begin
                raw_tick = 1'b0;
            end
            ST_INTERNAL: begin
                raw_tick = 1'b1;
            end
            ST_GATED: begin
                raw_tick  = gate_q[1];
                gate_fall = gate_q[2] & ~gate_q[1];
            end
            ST_EXT_SYNC: begin
                raw_tick = ext_q[1] & ~ext_q[2];
            end
            ST_EXT_RAW: begin
                raw_tick = ext_q[0] & ~ext_q[1];
            end
            default: begin
                raw_tick = 1'b0;
            end
        endcase
    end

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> !raw_tick) else $error("tick while off"); // R6

    AST_GATED_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GATED && raw_tick) |-> $past(gate_in, 2)) else $error("gate leak"); // R4

    AST_EXT_SYNC_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXT_SYNC && raw_tick) |-> ($past(ext_clk, 2) && !$past(ext_clk, 3)))
        else $error("sync edge"); // R5

endmodule

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int PRE_W = 8
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw_tick,
    input  logic       restart,
    input  logic [1:0] ps_code,
    output logic       tick
);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit;
    logic             at_limit;

    assign limit    = PRE_W'(ps_limit(ps_code));
    assign at_limit = (pre_cnt == limit);
    assign tick     = raw_tick && at_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pre_cnt <= '0;
        else if (restart)  pre_cnt <= '0;
        else if (raw_tick) pre_cnt <= at_limit ? '0 : pre_cnt + 1'b1;
    end

    AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= limit) else $error("prescale overrun"); // R3

endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
module tmr_count
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [REG_W-1:0] period,
    input  logic             load,
    input  logic [REG_W-1:0] load_val,
    output logic [REG_W-1:0] cnt,
    output logic             match_tick
);

    assign match_tick = tick && !load && (cnt == period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (match_tick) cnt <= '0;
        else if (tick)       cnt <= cnt + 1'b1;
    end

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        match_tick |=> (cnt == '0)) else $error("no wrap"); // R2

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt)) else $error("count moved"); // R6

endmodule

// File: rtl/tmr_gated_interval.sv
`timescale 1ns/1ps
module tmr_gated_interval
    import tmr_pkg::*;
#(
    parameter int PRE_W      = 8,
    parameter int SYNC_DEPTH = 3
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              ext_clk,
    input  logic              gate_in,
    output logic              evt_flag
);

    logic             en_bit, gate_bit, src_ext_bit, sync_bit;
    logic [1:0]       ps_code;
    logic [REG_W-1:0] period;
    logic [REG_W-1:0] cnt;
    logic [REG_W-1:0] cnt_load_val;
    logic             cnt_load, pre_restart;
    logic             raw_tick, gate_fall, tick, match_tick;
    logic             set_evt;

    assign set_evt = match_tick | gate_fall;

    tmr_regs i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .cnt_cur      (cnt),
        .set_evt      (set_evt),
        .en_bit       (en_bit),
        .gate_bit     (gate_bit),
        .src_ext_bit  (src_ext_bit),
        .sync_bit     (sync_bit),
        .ps_code      (ps_code),
        .period       (period),
        .flag         (evt_flag),
        .cnt_load     (cnt_load),
        .cnt_load_val (cnt_load_val),
        .pre_restart  (pre_restart),
        .bus_rdata    (bus_rdata)
    );

    tmr_srcsel #(.SYNC_DEPTH(SYNC_DEPTH)) i_srcsel (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_bit      (en_bit),
        .gate_bit    (gate_bit),
        .src_ext_bit (src_ext_bit),
        .sync_bit    (sync_bit),
        .ext_clk     (ext_clk),
        .gate_in     (gate_in),
        .raw_tick    (raw_tick),
        .gate_fall   (gate_fall)
    );

    tmr_prescale #(.PRE_W(PRE_W)) i_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_tick (raw_tick),
        .restart  (pre_restart),
        .ps_code  (ps_code),
        .tick     (tick)
    );

    tmr_count i_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .period     (period),
        .load       (cnt_load),
        .load_val   (cnt_load_val),
        .cnt        (cnt),
        .match_tick (match_tick)
    );

endmodule

// File: tb/test_tmr_gated_interval.sv
`timescale 1ns/1ps
module test_tmr_gated_interval;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'h4;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        ext_clk = 1'b0;
    logic        gate_in = 1'b0;
    logic        evt_flag;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit chk_en   = 1'b0;
    bit done     = 1'b0;
    string cur_req = "R10";

    tmr_gated_interval i_tmr_gated_interval (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
        .gate_in(gate_in), .evt_flag(evt_flag)
    );

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_ctrl, m_cnt, m_per, m_nctrl;
    bit          m_flag;
    int          m_mode, m_pre, md_lim;
    bit [2:0]    m_eh, m_gh;
    bit          md_raw, md_gfall, md_tick, md_match, md_restart;

    function automatic int divisor(input logic [1:0] c);
        case (c)
            2'd0: return 1;
            2'd1: return 8;
            2'd2: return 64;
            default: return 256;
        endcase
    endfunction

    function automatic logic [15:0] alias_op(input logic [15:0] o, input logic [15:0] d,
                                             input logic [1:0] op);
        case (op)
            2'd0: return d;
            2'd1: return o & ~d;
            2'd2: return o | d;
            default: return o ^ d;
        endcase
    endfunction

    function automatic int mode_of(input logic [15:0] c);
        if (!c[15]) return 0;
        if (c[1])   return c[2] ? 3 : 4;
        if (c[7])   return 2;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 16'h0; m_cnt = 16'h0; m_per = 16'hFFFF; m_flag = 1'b0;
            m_mode = 0; m_pre = 0; m_eh = 3'b0; m_gh = 3'b0;
        end else begin
            case (m_mode)
                1: md_raw = 1'b1;
                2: md_raw = m_gh[1];
                3: md_raw = m_eh[1] & ~m_eh[2];
                4: md_raw = m_eh[0] & ~m_eh[1];
                default: md_raw = 1'b0;
            endcase
            md_gfall = (m_mode == 2) && m_gh[2] && !m_gh[1];
            md_lim   = divisor(m_ctrl[5:4]) - 1;
            md_tick  = md_raw && (m_pre == md_lim);
            md_match = 1'b0;
            m_nctrl  = m_ctrl;
            if (bus_we && bus_addr[3:2] == 2'd0)
                m_nctrl = alias_op(m_ctrl, bus_wdata, bus_addr[1:0]) & 16'h80B6;
            md_restart = (bus_we && bus_addr[3:2] == 2'd1) ||
                         (m_nctrl[5:4] != m_ctrl[5:4]);
            if (bus_we && bus_addr[3:2] == 2'd1)
                m_cnt = alias_op(m_cnt, bus_wdata, bus_addr[1:0]);
            else if (md_tick) begin
                if (m_cnt == m_per) begin m_cnt = 16'h0; md_match = 1'b1; end
                else m_cnt = m_cnt + 16'h1;
            end
            if (md_restart)  m_pre = 0;
            else if (md_raw) m_pre = (m_pre == md_lim) ? 0 : m_pre + 1;
            if (bus_we && bus_addr[3:2] == 2'd2)
                m_per = alias_op(m_per, bus_wdata, bus_addr[1:0]);
            if (md_match || md_gfall) m_flag = 1'b1;
            else if (bus_we && bus_addr == 4'hD && bus_wdata[0]) m_flag = 1'b0;
            m_mode = mode_of(m_ctrl);
            m_ctrl = m_nctrl;
            m_eh = {m_eh[1:0], ext_clk};
            m_gh = {m_gh[1:0], gate_in};
        end
    end

    // Compare with the model every clock, away from the edge
    always @(posedge clk) begin
        #2;
        if (chk_en) begin
            case (bus_addr[3:2])
                2'd0: check(cur_req, bus_rdata, m_ctrl, "model ctrl");
                2'd1: check(cur_req, bus_rdata, m_cnt, "model count");
                2'd2: check(cur_req, bus_rdata, m_per, "model period");
                default: check(cur_req, bus_rdata, {15'h0, m_flag}, "model flag reg");
            endcase
            check(cur_req, evt_flag, m_flag, "model evt_flag");
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] sel, input logic [1:0] op, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = {sel, op}; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 4'h4; bus_wdata = 16'h0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] v);
        @(negedge clk);
        bus_addr = {sel, 2'b00};
        @(posedge clk); #2;
        v = bus_rdata;
        @(negedge clk);
        bus_addr = 4'h4;
    endtask

    task automatic sample_count(output logic [15:0] v);
        @(posedge clk); #2;
        v = bus_rdata;
    endtask

    task automatic wait_wrap(output int at);
        logic [15:0] prev, now;
        prev = 16'h0; at = -1;
        for (int i = 0; i < 5000; i++) begin
            sample_count(now);
            if (prev != 16'h0 && now == 16'h0) begin at = cyc; break; end
            prev = now;
        end
    endtask

    task automatic ext_edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_clk = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v, v0;
        int t0, t1, t2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset values
        cur_req = "R10";
        rd(2'd0, v); check("R10", v, 16'h0000, "ctrl after reset");
        rd(2'd1, v); check("R10", v, 16'h0000, "count after reset");
        rd(2'd2, v); check("R10", v, 16'hFFFF, "period after reset");
        rd(2'd3, v); check("R10", v, 16'h0000, "flag after reset");
        chk_en = 1'b1;

        // R7 aliases and reserved bits
        cur_req = "R7";
        wr(2'd2, 2'd0, 16'h1234); rd(2'd2, v); check("R7", v, 16'h1234, "period write");
        wr(2'd2, 2'd2, 16'h00F0); rd(2'd2, v); check("R7", v, 16'h12F4, "period set alias");
        wr(2'd2, 2'd1, 16'h0204); rd(2'd2, v); check("R7", v, 16'h10F0, "period clear alias");
        wr(2'd2, 2'd3, 16'hFFFF); rd(2'd2, v); check("R7", v, 16'hEF0F, "period invert alias");
        wr(2'd0, 2'd0, 16'h7FFF); rd(2'd0, v); check("R7", v, 16'h00B6, "ctrl reserved bits");
        wr(2'd0, 2'd0, 16'h0000);

        // R1 R2 R3 R6 R9 wrap timing per divisor
        for (int ps = 0; ps < 4; ps++) begin
            cur_req = "R3";
            wr(2'd2, 2'd0, 16'd4);
            wr(2'd1, 2'd0, 16'd0);
            wr(2'd0, 2'd0, 16'h8000 | 16'(ps << 4));
            wait_wrap(t0); wait_wrap(t1); wait_wrap(t2);
            check("R1", t1 - t0, 5 * divisor(2'(ps)), "wrap interval 1");
            check("R3", t2 - t1, 5 * divisor(2'(ps)), "wrap interval 2");
            rd(2'd3, v); check("R2", v, 16'h1, "flag after wrap");
            cur_req = "R6";
            wr(2'd0, 2'd1, 16'h8000);
            rd(2'd1, v0);
            repeat (40) @(negedge clk);
            rd(2'd1, v); check("R6", v, v0, "count held while disabled");
            cur_req = "R9";
            wr(2'd3, 2'd1, 16'h0001);
            rd(2'd3, v); check("R9", v, 16'h0, "flag cleared by clear alias");
        end

        // R9 stickiness against other writes to the flag register
        cur_req = "R9";
        wr(2'd2, 2'd0, 16'd2); wr(2'd1, 2'd0, 16'd0);
        wr(2'd0, 2'd0, 16'h8000);
        repeat (8) @(negedge clk);
        wr(2'd0, 2'd0, 16'h0000);
        wr(2'd3, 2'd0, 16'h0000); rd(2'd3, v); check("R9", v, 16'h1, "plain write keeps flag");
        wr(2'd3, 2'd3, 16'h0001); rd(2'd3, v); check("R9", v, 16'h1, "invert keeps flag");
        wr(2'd3, 2'd2, 16'h0000); rd(2'd3, v); check("R9", v, 16'h1, "set keeps flag");
        wr(2'd3, 2'd1, 16'h0001); rd(2'd3, v); check("R9", v, 16'h0, "clear drops flag");

        // R8 counter load restarts the prescaler
        cur_req = "R8";
        wr(2'd2, 2'd0, 16'd100); wr(2'd1, 2'd0, 16'd0);
        wr(2'd0, 2'd0, 16'h8010);
        repeat (13) @(negedge clk);
        wr(2'd1, 2'd0, 16'd2);
        for (int i = 1; i <= 8; i++) begin
            sample_count(v);
            check("R8", v, (i < 8) ? 16'd2 : 16'd3, "count after load");
        end
        wr(2'd0, 2'd0, 16'h8000);   // divisor change also restarts
        repeat (10) @(negedge clk);
        wr(2'd0, 2'd0, 16'h0000);

        // R4 gated counting
        cur_req = "R4";
        wr(2'd3, 2'd1, 16'h0001);
        wr(2'd2, 2'd0, 16'd1000); wr(2'd1, 2'd0, 16'd0);
        wr(2'd0, 2'd0, 16'h8080);
        repeat (6) @(negedge clk);
        rd(2'd1, v); check("R4", v, 16'd0, "no count with gate low");
        @(negedge clk); gate_in = 1'b1;
        repeat (10) @(negedge clk); gate_in = 1'b0;
        repeat (6) @(negedge clk);
        rd(2'd1, v); check("R4", v, 16'd10, "count over gate pulse");
        rd(2'd3, v); check("R4", v, 16'h1, "flag on gate fall");
        wr(2'd0, 2'd0, 16'h0000);
        wr(2'd3, 2'd1, 16'h0001);

        // R5 external clock, both sampling depths, gate bit ignored
        cur_req = "R5";
        wr(2'd1, 2'd0, 16'd0); wr(2'd0, 2'd0, 16'h8006);
        ext_edges(5); repeat (4) @(negedge clk);
        rd(2'd1, v); check("R5", v, 16'd5, "synchronized edges");
        wr(2'd0, 2'd0, 16'h0000); wr(2'd1, 2'd0, 16'd0); wr(2'd0, 2'd0, 16'h8002);
        ext_edges(5); repeat (4) @(negedge clk);
        rd(2'd1, v); check("R5", v, 16'd5, "single-flop edges");
        wr(2'd0, 2'd0, 16'h0000); wr(2'd1, 2'd0, 16'd0); wr(2'd0, 2'd0, 16'h8086);
        ext_edges(5); repeat (4) @(negedge clk);
        rd(2'd1, v); check("R5", v, 16'd5, "gate bit ignored with gate low");
        wr(2'd0, 2'd0, 16'h0000);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule